// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Receive Queue

This block receives asynchronous serial characters in the 8N1 format: one low start bit, eight data bits sent least significant bit first, and one high stop bit. It is timed by a single-cycle enable pulse that arrives at sixteen times the bit rate. The line is first passed through a two-stage synchroniser. A falling edge on the idle line opens a frame. The start bit is confirmed at its centre. Every later bit is sampled sixteen enable pulses after the previous sample, so each sample lands near the middle of its bit cell.

A frame whose stop bit reads high places its byte into a sixteen-entry first-in first-out queue. A frame whose stop bit reads low is thrown away. The receiver then stays parked until the line goes high again, so a line held low (a break) yields no bytes at all. The host reads the queue through a pop strobe. The oldest byte is always visible on the data output, and three level flags report the queue state.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the queue is empty and `has_data`, `half_level` and `is_full` are all low.
- R2: A falling edge on the idle line starts a frame. The start bit is confirmed on the 8th enable pulse after the edge, and each of the eight data bits is sampled 16 enable pulses after the previous sample. The first data bit received becomes bit 0 of the byte.
- R3: If the line is high when the start bit is confirmed, the event counts as a glitch: no byte is produced and the receiver goes back to waiting for a falling edge.
- R4: A byte is written to the queue only when its stop-bit sample is high. A frame whose stop sample is low produces no byte.
- R5: After a low stop sample, no new frame starts until the line has been high and then falls again. A line held low for many character times produces no bytes, and a valid frame sent after the line is released is received.
- R6: Frames sent with a bit period 3% shorter or 3% longer than nominal are received correctly.
- R7: The queue holds up to 16 bytes. They are delivered in the order they were received, and `pop_data` shows the oldest byte.
- R8: `has_data` is high when at least one byte is queued. `half_level` is high when 8 or more bytes are queued. `is_full` is high when 16 bytes are queued.
- R9: A byte that completes while the queue is full is dropped, and the queued bytes are left unchanged.
- R10: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick16 | input | 1 | One-cycle enable pulse at 16x the bit rate |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| pop | input | 1 | Removes the oldest queued byte |
| pop_data | output | 8 | Oldest queued byte |
| has_data | output | 1 | Queue is not empty |
| half_level | output | 1 | Queue holds at least half its capacity |
| is_full | output | 1 | Queue is full |

## Verification
The assertions check the following on every cycle:
- The queue count never passes its capacity.
- A write into a full queue, or a pop from an empty queue, leaves the level unchanged.
- The three flags stay consistent with each other.
- A start bit that is still low never drops the receiver back to idle.
- A parked receiver stays parked while the line is low.
- A byte strobe follows only a stop state whose sample was high.

Only the bench scenarios can show the following:
- Bits are assembled in the right order at nominal and offset rates.
- A glitch, a bad stop bit or a long break leaves nothing in the queue.
- Bytes come out in arrival order.
- A byte that arrives while the queue is full is lost and the queued bytes are intact.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

endpackage

// File: rtl/serial_sync.sv
module serial_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {STAGES{RESET_VAL}};
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import uart_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data
);

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic              prev_line;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        logic              valid;
    } framer_t;

    framer_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        r_d.valid     = 1'b0;
        r_d.prev_line = line;
        case (r_q.state)
            RX_IDLE: begin
                if (r_q.prev_line && !line) begin
                    r_d.state = RX_START;
                    r_d.cnt   = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (r_q.cnt == CNT_HALF) begin
                        r_d.cnt = '0;
                        r_d.idx = '0;
                        r_d.state = line ? RX_IDLE : RX_DATA;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (r_q.cnt == CNT_LAST) begin
                        r_d.cnt   = '0;
                        r_d.shreg = {line, r_q.shreg[DATA_W-1:1]};
                        if (r_q.idx == IDX_LAST) r_d.state = RX_STOP;
                        else                     r_d.idx   = r_q.idx + 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (r_q.cnt == CNT_LAST) begin
                        r_d.cnt = '0;
                        if (line) begin
                            r_d.valid = 1'b1;
                            r_d.state = RX_IDLE;
                        end else begin
                            r_d.state = RX_HOLD;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_HOLD: begin
                if (line) r_d.state = RX_IDLE;
            end
            default: r_d.state = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.state     <= RX_IDLE;
            r_q.prev_line <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_valid = r_q.valid;
    assign byte_data  = r_q.shreg;

    // R3: a start bit that is still low is never abandoned
    p_start_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_START && !line) |=> r_q.state != RX_IDLE);

    // R5: parked receiver stays parked while the line is low
    p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == RX_HOLD && !line) |=> r_q.state == RX_HOLD);

    // R4: a byte strobe only follows a stop state with a high sample
    p_valid_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |-> (r_q.state == RX_IDLE && $past(r_q.state) == RX_STOP && $past(line)));

    // R2: byte strobe lasts a single cycle
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.valid |=> !r_q.valid);

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         not_empty,
    output logic         half,
    output logic         full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
    localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rptr;
        logic [CW-1:0]           count;
    } fifo_t;

    fifo_t r_d, r_q;
    logic  do_wr, do_rd;

    always_comb begin
        r_d   = r_q;
        do_wr = wr_en && (r_q.count != CNT_FULL);
        do_rd = rd_en && (r_q.count != '0);
        if (do_wr) begin
            r_d.mem[r_q.wptr] = wr_data;
            r_d.wptr = (r_q.wptr == PTR_LAST) ? '0 : r_q.wptr + 1'b1;
        end
        if (do_rd) begin
            r_d.rptr = (r_q.rptr == PTR_LAST) ? '0 : r_q.rptr + 1'b1;
        end
        case ({do_wr, do_rd})
            2'b10:   r_d.count = r_q.count + 1'b1;
            2'b01:   r_d.count = r_q.count - 1'b1;
            default: r_d.count = r_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data   = r_q.mem[r_q.rptr];
    assign not_empty = (r_q.count != '0);
    assign half      = (r_q.count >= CNT_HALF);
    assign full      = (r_q.count == CNT_FULL);

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.count <= CNT_FULL);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(r_q.wptr)));

    p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && rd_en && !wr_en) |=> !not_empty);

    p_flag_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (half && not_empty));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DATA_W      = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick16,
    input  logic              rx_line,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              has_data,
    output logic              half_level,
    output logic              is_full
);

    logic              line_s;
    logic              rx_valid;
    logic [DATA_W-1:0] rx_byte;

    serial_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    rx_framer #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick16),
        .line      (line_s),
        .byte_valid(rx_valid),
        .byte_data (rx_byte)
    );

    byte_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (rx_valid),
        .wr_data  (rx_byte),
        .rd_en    (pop),
        .rd_data  (pop_data),
        .not_empty(has_data),
        .half     (half_level),
        .full     (is_full)
    );

endmodule

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;

    localparam int NOM = 64;   // clocks per bit: tick every 4 clocks x 16

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       has_data, half_level, is_full;
    logic [1:0] div = '0;
    int         errors = 0;
    int         checks = 0;

    always #10 clk = ~clk;   // 50 MHz

    always @(negedge clk) begin
        if (!rst_n) begin
            div  <= '0;
            tick <= 1'b0;
        end else begin
            div  <= div + 1'b1;
            tick <= (div == 2'd3);
        end
    end

    uart_rx_fifo dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick16(tick),
        .rx_line    (rx),
        .pop        (pop),
        .pop_data   (pop_data),
        .has_data   (has_data),
        .half_level (half_level),
        .is_full    (is_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_line(input logic v, input int clks);
        rx = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input int bclk, input logic stop_v);
        hold_line(1'b0, bclk);
        for (int i = 0; i < 8; i++) hold_line(b[i], bclk);
        hold_line(stop_v, bclk);
        if (stop_v) hold_line(1'b1, 16);
    endtask

    task automatic check_flags(input int n, input string req);
        chk(has_data == (n > 0), {req, " has_data"}, int'(has_data), int'(n > 0));
        chk(half_level == (n >= 8), {req, " half_level"}, int'(half_level), int'(n >= 8));
        chk(is_full == (n == 16), {req, " is_full"}, int'(is_full), int'(n == 16));
    endtask

    task automatic pop_check(input logic [7:0] exp, input string req);
        chk(has_data == 1'b1, {req, " byte present"}, int'(has_data), 1);
        chk(pop_data == exp, {req, " data"}, int'(pop_data), int'(exp));
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [7:0] b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        check_flags(0, "R1");

        // R2: walking ones and zeros at nominal rate, LSB first
        for (int k = 0; k < 8; k++) begin
            b = 8'(1 << k);
            send_frame(b, NOM, 1'b1);
            pop_check(b, "R2");
            send_frame(~b, NOM, 1'b1);
            pop_check(~b, "R2");
        end

        // R7/R8: fill the queue, tracking flags per level
        for (int k = 0; k < 16; k++) begin
            send_frame(8'(k * 17 + 3), NOM, 1'b1);
            check_flags(k + 1, "R8");
        end
        // R9: byte arriving while full is dropped
        send_frame(8'hEE, NOM, 1'b1);
        check_flags(16, "R9");
        for (int k = 0; k < 16; k++) begin
            pop_check(8'(k * 17 + 3), "R7 R9");
            check_flags(15 - k, "R8");
        end

        // R10: pop on empty has no effect
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        check_flags(0, "R10");
        send_frame(8'h96, NOM, 1'b1);
        check_flags(1, "R10");
        pop_check(8'h96, "R10");
        check_flags(0, "R10");

        // R6: rate offsets of -3% and +3%
        for (int k = 0; k < 24; k++) begin
            b = 8'(k * 11 + 7);
            send_frame(b, 62, 1'b1);
            pop_check(b, "R6 fast");
            send_frame(~b, 66, 1'b1);
            pop_check(~b, "R6 slow");
        end

        // R3: short low glitch is rejected
        hold_line(1'b0, 12);
        hold_line(1'b1, NOM * 11);
        check_flags(0, "R3");
        send_frame(8'h5A, NOM, 1'b1);
        pop_check(8'h5A, "R3");

        // R4: low stop bit discards the frame
        send_frame(8'hA5, NOM, 1'b0);
        hold_line(1'b0, NOM * 2);
        hold_line(1'b1, NOM * 2);
        check_flags(0, "R4");
        send_frame(8'hC3, NOM, 1'b1);
        pop_check(8'hC3, "R4");

        // R5: long break yields nothing; next valid frame accepted
        hold_line(1'b0, NOM * 40);
        check_flags(0, "R5");
        hold_line(1'b1, NOM);
        check_flags(0, "R5");
        send_frame(8'h3C, NOM, 1'b1);
        check_flags(1, "R5");
        pop_check(8'h3C, "R5");
        check_flags(0, "R5");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule